// File: doc/BRIEF.md
# Double-Buffered DAC Register Controller

This block is the synchronous control logic that sits in front of a parallel-loaded digital-to-analog converter. It keeps two stages of the code. The input stage takes a word from the parallel data bus, and the converter stage holds the code that is presented to the converter. There are four active-low controls: chip select, write strobe, load strobe and clear. They come from outside the clock domain, so each one is resynchronized. The level-sensitive latch behaviour is then reproduced with clock-enabled registers. The data bus goes through the same synchronizer depth, so a control pattern and the data presented with it arrive at the logic together.

The load strobe is independent of the write strobe. A small state machine tracks the converter stage with three states. ST_HOLD means the stage is closed. ST_TRACK means the load strobe is low and the stage is transparent. ST_DEFER means the load strobe was released while a write was still in progress, so the stage keeps tracking until the write ends.

The transitions are:
- TRACK_ENTER (ST_HOLD to ST_TRACK) when the load strobe goes low.
- CAPTURE (ST_TRACK to ST_HOLD) when the load strobe is released with no write active.
- POSTPONE (ST_TRACK to ST_DEFER) when the load strobe is released during a write.
- WRITE_DONE (ST_DEFER to ST_HOLD) when the write ends.
- RELOAD (ST_DEFER to ST_TRACK) when the load strobe falls again.

Clear forces the converter stage to zero. Whether that zero stays after clear is released depends on whether the stages are open or closed at the time.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: When chip select, write and load are all low and clear is high, `dac_code` follows `din`. A change on `din` appears at the third rising clock edge after it is sampled.
- R2: The input stage loads `din` while chip select and write are both low, and holds otherwise. With load high, `dac_code` does not change during or after such a write.
- R3: With load low and no write active, `dac_code` equals the input stage contents. When load returns high, that value is kept.
- R4: If load goes high while a write is still active, `dac_code` keeps following `din` until the write ends. It then holds the last value written.
- R5: While clear is low, `dac_code` is all zeros, whatever the other three controls are.
- R6: `zero_ovr` is 1 exactly while clear, chip select, write and load are all low. After clear returns high in that condition, `dac_code` follows `din` again.
- R7: When clear pulses low while load is high, `dac_code` stays all zeros after clear returns high, until the next load.
- R8: After reset, `dac_code` is zero and `zero_ovr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ld_n | input | 1 | Load strobe to converter stage, active low, asynchronous |
| clr_n | input | 1 | Clear, active low, asynchronous |
| din | input | DATA_W | Parallel data bus |
| dac_code | output | DATA_W | Code held in the converter stage |
| zero_ovr | output | 1 | Zero override active |

## Verification
The bench builds the block with DATA_W = 4. This makes it possible to push every data code through the transparent path. The bench also applies all sixteen patterns of the four controls, each from a primed state in which the two stages hold different values. For each pattern it checks the result while the pattern is applied, after clear is released and after the controls return to idle. This separates a temporary zero from a sticky one, and shows whether the code came from the bus or from the input stage. A directed sequence releases the load strobe in the middle of a write to exercise the ST_DEFER path.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_TRACK = 2'd1,
        ST_DEFER = 2'd2
    } dac_st_e;

    localparam int CTL_W = 4;

endpackage

// File: rtl/dbuf_sync.sv
module dbuf_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dbuf_in_latch.sv
module dbuf_in_latch #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= d;
    end
endmodule

// File: rtl/dbuf_dac_latch.sv
module dbuf_dac_latch
    import dac_dbuf_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_act,
    input  logic         wr_act,
    input  logic         clr_act,
    input  logic [W-1:0] din_s,
    input  logic [W-1:0] in_q,
    output logic [W-1:0] dac_q,
    output dac_st_e      state
);
    dac_st_e     state_nx;
    logic        open_c;
    logic [W-1:0] src_c;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    // Transition logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:  if (ld_act) state_nx = ST_TRACK;
            ST_TRACK: if (!ld_act) state_nx = wr_act ? ST_DEFER : ST_HOLD;
            ST_DEFER: begin
                if (ld_act)       state_nx = ST_TRACK;
                else if (!wr_act) state_nx = ST_HOLD;
            end
            default:  state_nx = ST_HOLD;
        endcase
    end

    // Converter stage is open while load is active or until a pending capture
    assign open_c = ld_act || (state != ST_HOLD);
    // With both stages open, the bus flows straight through
    assign src_c  = wr_act ? din_s : in_q;

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dac_q <= '0;
        else if (clr_act) dac_q <= '0;
        else if (open_c)  dac_q <= src_c;
    end
endmodule

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl
    import dac_dbuf_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic              clr_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dac_code,
    output logic              zero_ovr
);
    logic [CTL_W-1:0]  ctl_s;
    logic [DATA_W-1:0] din_s;
    logic [DATA_W-1:0] in_q;
    logic              cs_act, wr_act, ld_act, clr_act, wr_go;
    dac_st_e           dac_st;

    dbuf_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, wr_n, ld_n, clr_n}), .q(ctl_s)
    );

    dbuf_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
    );

    assign cs_act  = ~ctl_s[3];
    assign wr_act  = ~ctl_s[2];
    assign ld_act  = ~ctl_s[1];
    assign clr_act = ~ctl_s[0];
    assign wr_go   = cs_act & wr_act;

    dbuf_in_latch #(.W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .d(din_s), .q(in_q)
    );

    dbuf_dac_latch #(.W(DATA_W)) u_dac (
        .clk(clk), .rst_n(rst_n), .ld_act(ld_act), .wr_act(wr_go),
        .clr_act(clr_act), .din_s(din_s), .in_q(in_q),
        .dac_q(dac_code), .state(dac_st)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zero_ovr <= 1'b0;
        else        zero_ovr <= clr_act & wr_go & ld_act;
    end
endmodule

// File: rtl/dac_dbuf_chk.sv
module dac_dbuf_chk
    import dac_dbuf_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input dac_st_e           st,
    input logic              wr_go,
    input logic              ld_act,
    input logic              clr_act,
    input logic [DATA_W-1:0] din_s,
    input logic [DATA_W-1:0] in_q,
    input logic [DATA_W-1:0] dac_code,
    input logic              zero_ovr
);
    assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && ld_act && !clr_act) |=> dac_code == $past(din_s));

    assert_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> $stable(in_q));

    assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_act && !wr_go && !clr_act) |=> dac_code == $past(in_q));

    assert_defer_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEFER && wr_go && !clr_act) |=> dac_code == $past(din_s));

    assert_clr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> dac_code == '0);

    assert_ovr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        zero_ovr |-> dac_code == '0);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !ld_act && !clr_act) |=> $stable(dac_code));
endmodule

bind dac_dbuf_ctrl dac_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(dac_st), .wr_go(wr_go), .ld_act(ld_act),
    .clr_act(clr_act), .din_s(din_s), .in_q(in_q), .dac_code(dac_code),
    .zero_ovr(zero_ovr)
);

// File: tb/dac_dbuf_ctrl_bench.sv
`timescale 1ns/1ps
module dac_dbuf_ctrl_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dac_code;
    logic         zero_ovr;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] m_in = '0, m_dac = '0;
    logic         m_ovr = 1'b0;

    always #2.5 clk = ~clk;

    dac_dbuf_ctrl #(.DATA_W(W), .SYNC_STAGES(2)) u_dac_dbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
        .clr_n(clr_n), .din(din), .dac_code(dac_code), .zero_ovr(zero_ovr)
    );

    task automatic check(input string tag, input logic [W-1:0] exp_code, input logic exp_ovr);
        checks++;
        if (dac_code !== exp_code || zero_ovr !== exp_ovr) begin
            fails++;
            $display("FAIL %s: code=%0d ovr=%0b expected code=%0d ovr=%0b",
                     tag, dac_code, zero_ovr, exp_code, exp_ovr);
        end
    endtask

    // Drive a control pattern, let it settle through the synchronizers, update the model
    task automatic step(input logic c, input logic w, input logic l, input logic r,
                        input logic [W-1:0] d);
        @(negedge clk);
        cs_n = c; wr_n = w; ld_n = l; clr_n = r; din = d;
        repeat (5) @(posedge clk);
        @(negedge clk);
        if (!c && !w) m_in = d;
        if (!r)      m_dac = '0;
        else if (!l) m_dac = m_in;
        m_ovr = !r && !c && !w && !l;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset", '0, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8 after reset", '0, 1'b0);

        // R1: every code through the fully transparent path
        for (int v = 0; v < (1 << W); v++) begin
            step(0, 0, 0, 1, W'(v));
            check("R1 transparent", W'(v), 1'b0);
        end
        // R1 latency: the new code is present at the third rising edge, not the second
        @(negedge clk);
        din = W'(5);
        repeat (2) @(posedge clk);
        #1;
        check("R1 latency early", W'(15), 1'b0);
        @(posedge clk);
        #1;
        check("R1 latency edge3", W'(5), 1'b0);
        m_in = W'(5); m_dac = W'(5);
        step(1, 1, 1, 1, W'(5));

        // Every control pattern from a primed state (input stage != converter stage)
        for (int c = 0; c < 16; c++) begin
            logic [W-1:0] p1, p2, p3;
            logic cs, wr, ld, cl;
            string tag;
            p1 = W'(c * 3 + 1);
            p2 = W'(c * 5 + 2) ^ W'(8);
            p3 = W'(c * 7 + 9);
            if (p2 == p1) p2 = p1 + W'(1);
            if (p3 == p1 || p3 == p2) p3 = p1 + p2 + W'(3);
            cs = c[3]; wr = c[2]; ld = c[1]; cl = c[0];
            step(1, 1, 1, 1, p1);
            step(0, 0, 1, 1, p1);
            step(1, 1, 1, 1, p2);
            step(1, 1, 0, 1, p2);
            step(1, 1, 1, 1, p2);
            step(0, 0, 1, 1, p2);
            step(1, 1, 1, 1, p3);
            check("R2 primed hold", p1, 1'b0);
            if (!cl)              tag = (!cs && !wr && !ld) ? "R6 override" : "R5 clear";
            else if (!ld)         tag = (!cs && !wr) ? "R1 both open" : "R3 load copy";
            else                  tag = "R2 input only";
            step(cs, wr, ld, cl, p3);
            check(tag, m_dac, m_ovr);
            step(cs, wr, ld, 1, p3);
            check(!cl ? (ld ? "R7 sticky" : "R6 release") : tag, m_dac, m_ovr);
            step(1, 1, 1, 1, p3);
            check(!cl && ld ? "R7 sticky idle" : "R3 idle hold", m_dac, m_ovr);
        end

        // R4: load released during a write keeps tracking until the write ends
        step(1, 1, 1, 1, W'(0));
        @(negedge clk); cs_n = 0; wr_n = 0; ld_n = 0; din = W'(3);
        repeat (5) @(posedge clk); @(negedge clk);
        check("R4 open", W'(3), 1'b0);
        ld_n = 1; din = W'(10);
        repeat (5) @(posedge clk); @(negedge clk);
        check("R4 defer tracks", W'(10), 1'b0);
        din = W'(12);
        repeat (5) @(posedge clk); @(negedge clk);
        check("R4 defer tracks again", W'(12), 1'b0);
        cs_n = 1; wr_n = 1;
        repeat (5) @(posedge clk); @(negedge clk);
        check("R4 final held", W'(12), 1'b0);
        din = W'(6);
        repeat (5) @(posedge clk); @(negedge clk);
        check("R4 bus ignored", W'(12), 1'b0);
        ld_n = 0;
        repeat (5) @(posedge clk); @(negedge clk);
        check("R4 input stage kept", W'(12), 1'b0);
        ld_n = 1;
        repeat (3) @(posedge clk); @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule